// File: doc/BRIEF.md
# Dual-Bank Bulk-IN Transmit Buffer

This block is the transmit side of a bulk-IN endpoint. Software loads packets through a single byte write port. It never chooses a bank. Behind that port sit two storage banks of `DEPTH` bytes each, which are used alternately. A commit strobe closes the bank being filled, records its byte count, and moves the write side to the other bank. One strobe always closes exactly one bank, so every packet needs its own strobe.

The serial engine presents IN tokens. If the oldest committed bank holds a packet, the block answers ACK. The engine then streams the bytes out with a read strobe and reports the end of the transmission. A transmission the host acknowledged frees the bank. A failed one rewinds the bank to its first byte for a retry. With no committed packet, the block answers NACK and raises a transfer-request flag.

An empty flag reports that at least one bank can accept data. The two flags, each gated by its own enable, are ORed into one interrupt line.

Top module: `bulk_in_pingpong`

## Requirements
- R1: After reset both banks are free and nothing is committed. `empty_o`=1, `xfer_req_o`=0, `overflow_o`=0, `resp_valid_o`=0 and `tx_len_o`=0.
- R2: Commits alternate between the two banks. Committed packets are offered to the engine in commit order, and each packet's bytes come out in the order they were written.
- R3: One `pkt_commit_i` pulse commits only the bank being filled. Suppose 128 bytes are written to an empty buffer with `DEPTH`=64 and then one commit is issued. The result is a single 64-byte packet holding the first 64 bytes, and the other bank stays uncommitted.
- R4: Suppose an `in_token_i` arrives while no bank is committed. In the next cycle `resp_valid_o`=1 and `resp_ack_o`=0 (NACK), and `xfer_req_o`=1.
- R5: Suppose an `in_token_i` arrives while a committed packet is waiting. In the next cycle `resp_valid_o`=1 and `resp_ack_o`=1 (ACK). `tx_len_o` shows that packet's byte count, and `tx_data_o` shows the byte at the current read position, which each `tx_rd_i` pulse advances.
- R6: A `tx_done_i` pulse with `tx_ok_i`=1 frees the head bank. With `tx_ok_i`=0 the bank stays committed, keeps its count, and the read position returns to byte 0.
- R7: `empty_o` is 1 in every cycle in which at least one bank is uncommitted. A `clr_empty_i` pulse clears it only while both banks are committed, and it is set again once a bank is freed.
- R8: A `clr_xfer_req_i` pulse clears `xfer_req_o`. If a NACK happens in the same cycle, the flag stays set.
- R9: `irq_o` = (`xfer_req_o` AND `xfer_ie_i`) OR (`empty_o` AND `empty_ie_i`). With both banks free after reset, raising `empty_ie_i` raises `irq_o` at once.
- R10: A byte written while the fill bank holds `DEPTH` bytes, or while both banks are committed, is dropped. The drop sets `overflow_o`, which stays set until reset.
- R11: If a commit and a successful release happen in the same cycle, both take effect. `empty_o` is 1 after that cycle.
- R12: A commit while both banks are committed is ignored.
- R13: Packets of any length from 0 to `DEPTH` bytes are committed with their exact count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Byte write strobe |
| wr_data_i | input | DW | Byte to append to the fill bank |
| pkt_commit_i | input | 1 | Commit the fill bank as a packet |
| in_token_i | input | 1 | IN token from the serial engine |
| resp_valid_o | output | 1 | Handshake answer valid, one cycle after a token |
| resp_ack_o | output | 1 | 1 = ACK, 0 = NACK |
| tx_rd_i | input | 1 | Advance read position in the head packet |
| tx_data_o | output | DW | Byte at the read position |
| tx_len_o | output | $clog2(DEPTH+1) | Byte count of the head packet, 0 if none |
| tx_done_i | input | 1 | Transmission of the head packet finished |
| tx_ok_i | input | 1 | Host acknowledged that transmission |
| clr_xfer_req_i | input | 1 | Software clear of the transfer-request flag |
| clr_empty_i | input | 1 | Software clear of the empty flag |
| xfer_ie_i | input | 1 | Transfer-request interrupt enable |
| empty_ie_i | input | 1 | Empty interrupt enable |
| xfer_req_o | output | 1 | Transfer-request flag |
| empty_o | output | 1 | Empty flag |
| irq_o | output | 1 | Combined interrupt |
| overflow_o | output | 1 | Sticky dropped-write flag |

## Verification
Handshake answers and both flags are registered, so they are due one cycle after the strobe that caused them. `tx_data_o`, `tx_len_o` and `irq_o` follow the current state without delay. The bench changes inputs on the falling edge and holds every strobe for exactly one rising edge. It compares at the next falling edge, one cycle after the strobe, which is where registered results first appear. It checks the combinational outputs again after a short settle when only an enable changed. The packet lengths are swept over 0, 1, 2, 17, 63 and 64 bytes. Each byte is compared against an arithmetic pattern of packet seed and index.

// File: rtl/bip_pkg.sv
package bip_pkg;
  localparam int unsigned NUM_BANKS = 2;
  typedef enum logic {
    RESP_NACK = 1'b0,
    RESP_ACK  = 1'b1
  } resp_e;
endpackage

// File: rtl/bip_bank.sv
module bip_bank #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          commit_i,
  input  logic          release_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] cnt_o,
  output logic          committed_o,
  output logic          full_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          committed_q;

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[cnt_q[AW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      committed_q <= 1'b0;
    end else if (release_i) begin
      cnt_q       <= '0;
      committed_q <= 1'b0;
    end else begin
      if (wr_i)     cnt_q       <= cnt_q + 1'b1;
      if (commit_i) committed_q <= 1'b1;
    end
  end

  assign rd_data_o   = mem_q[rd_idx_i];
  assign cnt_o       = cnt_q;
  assign committed_o = committed_q;
  assign full_o      = (cnt_q == CW'(DEPTH));

  assert_wr_open_bank_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> (!committed_q && !full_o));
  assert_release_committed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |-> committed_q);
  assert_cnt_bound_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_commit_keeps_cnt_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (committed_q && !release_i) |=> $stable(cnt_q));
endmodule

// File: rtl/bip_status.sv
module bip_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nack_i,
  input  logic any_free_i,
  input  logic clr_xfer_i,
  input  logic clr_empty_i,
  input  logic xfer_ie_i,
  input  logic empty_ie_i,
  output logic xfer_req_o,
  output logic empty_o,
  output logic irq_o
);
  logic xfer_q, empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xfer_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      // set dominates software clear
      if (nack_i)          xfer_q <= 1'b1;
      else if (clr_xfer_i) xfer_q <= 1'b0;
      if (any_free_i)       empty_q <= 1'b1;
      else if (clr_empty_i) empty_q <= 1'b0;
    end
  end

  assign xfer_req_o = xfer_q;
  assign empty_o    = empty_q;
  assign irq_o      = (xfer_q & xfer_ie_i) | (empty_q & empty_ie_i);

  assert_nack_sets_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_i |=> xfer_req_o);
  assert_clr_drops_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_xfer_i && !nack_i) |=> !xfer_req_o);
  assert_free_sets_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_free_i |=> empty_o);
  assert_req_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && !clr_xfer_i) |=> xfer_req_o);
endmodule

// File: rtl/bulk_in_pingpong.sv
module bulk_in_pingpong #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned NB   = bip_pkg::NUM_BANKS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          pkt_commit_i,
  input  logic          in_token_i,
  output logic          resp_valid_o,
  output logic          resp_ack_o,
  input  logic          tx_rd_i,
  output logic [DW-1:0] tx_data_o,
  output logic [CW-1:0] tx_len_o,
  input  logic          tx_done_i,
  input  logic          tx_ok_i,
  input  logic          clr_xfer_req_i,
  input  logic          clr_empty_i,
  input  logic          xfer_ie_i,
  input  logic          empty_ie_i,
  output logic          xfer_req_o,
  output logic          empty_o,
  output logic          irq_o,
  output logic          overflow_o
);
  import bip_pkg::*;

  logic          wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] byte_idx_q;
  logic          ovf_q;
  logic          resp_valid_q;
  resp_e         resp_q;

  logic [NB-1:0] committed, full, wr_sel, commit_sel, rel_sel, committed_next;
  logic [DW-1:0] rd_data [NB];
  logic [CW-1:0] cnt     [NB];

  logic wr_ok, commit_ok, head_valid, release_ok, nack, any_free;

  assign head_valid = committed[rd_ptr_q];
  assign wr_ok      = wr_en_i & ~committed[wr_ptr_q] & ~full[wr_ptr_q];
  assign commit_ok  = pkt_commit_i & ~committed[wr_ptr_q];
  assign release_ok = tx_done_i & tx_ok_i & head_valid;
  assign nack       = in_token_i & ~head_valid;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign wr_sel[b]         = wr_ok     & (wr_ptr_q == 1'(b));
    assign commit_sel[b]     = commit_ok & (wr_ptr_q == 1'(b));
    assign rel_sel[b]        = release_ok & (rd_ptr_q == 1'(b));
    assign committed_next[b] = (committed[b] | commit_sel[b]) & ~rel_sel[b];

    bip_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (wr_sel[b]),
      .wr_data_i   (wr_data_i),
      .commit_i    (commit_sel[b]),
      .release_i   (rel_sel[b]),
      .rd_idx_i    (byte_idx_q[AW-1:0]),
      .rd_data_o   (rd_data[b]),
      .cnt_o       (cnt[b]),
      .committed_o (committed[b]),
      .full_o      (full[b])
    );
  end

  assign any_free = ~&committed_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q     <= 1'b0;
      rd_ptr_q     <= 1'b0;
      byte_idx_q   <= '0;
      ovf_q        <= 1'b0;
      resp_valid_q <= 1'b0;
      resp_q       <= RESP_NACK;
    end else begin
      if (commit_ok) wr_ptr_q <= ~wr_ptr_q;
      if (wr_en_i && !wr_ok) ovf_q <= 1'b1;
      resp_valid_q <= in_token_i;
      if (in_token_i) resp_q <= head_valid ? RESP_ACK : RESP_NACK;
      if (tx_done_i && head_valid) begin
        byte_idx_q <= '0;
        if (tx_ok_i) rd_ptr_q <= ~rd_ptr_q;
      end else if (tx_rd_i && head_valid && (byte_idx_q < cnt[rd_ptr_q])) begin
        byte_idx_q <= byte_idx_q + 1'b1;
      end
    end
  end

  assign resp_valid_o = resp_valid_q;
  assign resp_ack_o   = (resp_q == RESP_ACK);
  assign tx_data_o    = rd_data[rd_ptr_q];
  assign tx_len_o     = head_valid ? cnt[rd_ptr_q] : '0;
  assign overflow_o   = ovf_q;

  bip_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .nack_i      (nack),
    .any_free_i  (any_free),
    .clr_xfer_i  (clr_xfer_req_i),
    .clr_empty_i (clr_empty_i),
    .xfer_ie_i   (xfer_ie_i),
    .empty_ie_i  (empty_ie_i),
    .xfer_req_o  (xfer_req_o),
    .empty_o     (empty_o),
    .irq_o       (irq_o)
  );

  assert_one_commit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(committed & ~$past(committed)) <= 1);
  assert_release_frees_head_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_ok |=> !committed[$past(rd_ptr_q)]);
  assert_ack_on_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_token_i && head_valid) |=> (resp_valid_o && resp_ack_o));
  assert_empty_when_free_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&committed) |-> empty_o);
  assert_ovf_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
endmodule

// File: tb/bulk_in_pingpong_tb_top.sv
module bulk_in_pingpong_tb_top;
  localparam int DW = 8, DEPTH = 64, CW = $clog2(DEPTH + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic wr_en_i = 0, pkt_commit_i = 0, in_token_i = 0, tx_rd_i = 0, tx_done_i = 0, tx_ok_i = 0;
  logic clr_xfer_req_i = 0, clr_empty_i = 0, xfer_ie_i = 0, empty_ie_i = 0;
  logic [DW-1:0] wr_data_i = '0;
  logic resp_valid_o, resp_ack_o, xfer_req_o, empty_o, irq_o, overflow_o;
  logic [DW-1:0] tx_data_o;
  logic [CW-1:0] tx_len_o;

  bulk_in_pingpong #(.DW(DW), .DEPTH(DEPTH)) dut_i (.*);

  int  n_cmp = 0, n_bad = 0;
  bit  finished = 0;

  function automatic int pat(int seed, int i);
    return (seed * 7 + i * 13 + 5) & 255;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
    wr_en_i = 0; pkt_commit_i = 0; in_token_i = 0; tx_rd_i = 0;
    tx_done_i = 0; tx_ok_i = 0; clr_xfer_req_i = 0; clr_empty_i = 0;
  endtask

  task automatic write_pkt(input int seed, input int len);
    for (int i = 0; i < len; i++) begin
      wr_en_i = 1; wr_data_i = DW'(pat(seed, i)); cyc();
    end
  endtask

  task automatic commit();
    pkt_commit_i = 1; cyc();
  endtask

  task automatic token(input string req, input int exp_ack);
    in_token_i = 1; cyc();
    chk({req, " resp_valid"}, resp_valid_o, 1);
    chk({req, " resp_ack"}, resp_ack_o, exp_ack);
  endtask

  task automatic finish_tx(input bit ok);
    tx_done_i = 1; tx_ok_i = ok; cyc();
  endtask

  task automatic read_chk(input string req, input int seed, input int len);
    for (int i = 0; i < len; i++) begin
      chk({req, " tx_data"}, tx_data_o, pat(seed, i));
      tx_rd_i = 1; cyc();
    end
  endtask

  task automatic send_pkt(input string req, input int seed, input int len);
    token(req, 1);
    chk({req, " tx_len"}, tx_len_o, len);
    read_chk(req, seed, len);
    finish_tx(1);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung, expected completion");
      report();
      $finish;
    end
  end

  initial begin
    int lens[6] = '{0, 1, 2, 17, 63, 64};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 empty", empty_o, 1);
    chk("R1 xfer_req", xfer_req_o, 0);
    chk("R1 overflow", overflow_o, 0);
    chk("R1 resp_valid", resp_valid_o, 0);
    chk("R1 tx_len", tx_len_o, 0);
    chk("R1 irq", irq_o, 0);

    // R4 NACK with nothing committed, R9 / R8 flag handling
    token("R4", 0);
    chk("R4 xfer_req", xfer_req_o, 1);
    xfer_ie_i = 1; #1;
    chk("R9 irq xfer", irq_o, 1);
    clr_xfer_req_i = 1; cyc();
    chk("R8 clear", xfer_req_o, 0);
    chk("R9 irq off", irq_o, 0);
    in_token_i = 1; clr_xfer_req_i = 1; cyc();
    chk("R8 set wins", xfer_req_o, 1);
    clr_xfer_req_i = 1; cyc();
    chk("R8 clear again", xfer_req_o, 0);
    xfer_ie_i = 0;

    // R9 empty interrupt fires at once; R7 clear ignored while free
    empty_ie_i = 1; #1;
    chk("R9 irq empty", irq_o, 1);
    clr_empty_i = 1; cyc();
    chk("R7 clear while free", empty_o, 1);
    empty_ie_i = 0;

    // R13 / R5 length sweep
    foreach (lens[k]) begin
      write_pkt(k + 1, lens[k]);
      commit();
      send_pkt("R13 R5", k + 1, lens[k]);
      chk("R7 empty after send", empty_o, 1);
    end

    // R2 ordering, R6 retry, R7, R10, R12
    write_pkt(100, 5); commit();
    write_pkt(200, 9); commit();
    chk("R7 empty still set", empty_o, 0 + 1);
    clr_empty_i = 1; cyc();
    chk("R7 clear when both committed", empty_o, 0);
    chk("R10 no overflow yet", overflow_o, 0);
    wr_en_i = 1; wr_data_i = 8'hEE; cyc();
    chk("R10 overflow", overflow_o, 1);
    commit();  // R12 ignored
    token("R2", 1);
    chk("R2 first len", tx_len_o, 5);
    read_chk("R2", 100, 2);
    finish_tx(0);
    chk("R6 rewind data", tx_data_o, pat(100, 0));
    chk("R6 len kept", tx_len_o, 5);
    chk("R6 bank kept", empty_o, 0);
    send_pkt("R6 retry", 100, 5);
    chk("R7 set on release", empty_o, 1);
    send_pkt("R2 second", 200, 9);
    token("R12 nothing extra", 0);
    clr_xfer_req_i = 1; cyc();

    // R3 128 writes, one strobe
    write_pkt(33, 128);
    commit();
    send_pkt("R3", 33, 64);
    token("R3 other bank empty", 0);
    chk("R10 sticky", overflow_o, 1);
    clr_xfer_req_i = 1; cyc();

    // R11 commit and release together
    write_pkt(50, 3); commit();
    write_pkt(60, 4);
    token("R11", 1);
    chk("R11 len", tx_len_o, 3);
    read_chk("R11", 50, 3);
    pkt_commit_i = 1; tx_done_i = 1; tx_ok_i = 1; cyc();
    chk("R11 empty", empty_o, 1);
    send_pkt("R11 committed", 60, 4);
    write_pkt(70, 2); commit();
    send_pkt("R11 reuse", 70, 2);
    chk("R1 empty end", empty_o, 1);

    finished = 1;
    report();
    $finish;
  end
endmodule